// File: doc/BRIEF.md
# Card Bus Power-Up Initialization Sequencer

This block is the host-side controller that takes a card bus from cold power-up into card identification. After reset it keeps the bus quiet until the supply monitor reports that the rail is at its operating level. It then enables the bus clock and drives the command line continuously high for a wake-up period. That period is the longest of three limits: one millisecond expressed in clock cycles, a fixed floor of 74 cycles, and a supply ramp time given in cycles on an input.

After the wake-up period the sequencer sends the operating-condition command (index 1) and passes the host's operating voltage window as the 32-bit argument. It reads only the busy flag of each response. While any card reports busy it keeps sending the same command, up to a fixed number of attempts. When a response shows that the cards are ready, it sends the identification command (index 2) and gives a one-cycle completion pulse. Between commands the command line idles high for a fixed gap. Serialization, CRC and response decoding are handled by a separate command engine. That engine takes requests through a valid/ready handshake and returns one response strobe per command.

States: WAIT_POWER (bus quiet) goes to INIT_ONES when the supply is good. INIT_ONES goes to SEND_CMD1 when the wake-up count expires. SEND_CMD1 goes to WAIT_RESP when the engine accepts the request. WAIT_RESP goes to GAP on a response, or to ERROR on a busy response once the attempts are used up. GAP goes to SEND_CMD1 after a busy response and to SEND_CMD2 after a ready response. SEND_CMD2 goes to DONE when the engine accepts it. DONE and ERROR hold until reset.

Top module: `cardbus_pwrup_seq`

## Requirements
- R1: From reset until `pwr_ok` is sampled high, `bus_clk_en`, `cmd_ones`, `req_valid`, `done` and `timeout` are all 0.
- R2: In the cycle after `pwr_ok` is sampled high, `bus_clk_en` rises and then stays at 1 until reset. `cmd_ones` is 1 for exactly N consecutive cycles, where N = max(CLK_KHZ, 74, `ramp_cycles` sampled at the moment power is seen).
- R3: The wake-up length never drops below 74 cycles (64 readiness cycles plus 10 margin cycles), even when both the millisecond count and the ramp count are smaller.
- R4: In the cycle after the last wake-up cycle, the first request appears with `req_index` = 1 and `req_arg` = `ocr_window`.
- R5: A request holds `req_valid`, `req_index` and `req_arg` steady until `req_ready` is sampled high. `req_valid` is 0 in the next cycle.
- R6: A response with `rsp_busy` = 1 to the operating-condition command leads to another index-1 request after the gap, provided fewer than MAX_TRIES attempts have been accepted.
- R7: An index-2 request with `req_arg` = 0 is issued only after a response with `rsp_busy` = 0.
- R8: After each response that does not end the sequence, `cmd_ones` is 1 for exactly NCC cycles, and the next request follows in the cycle right after.
- R9: If the response to the MAX_TRIES-th accepted index-1 request is busy, `timeout` rises in the next cycle and stays high until reset, and no further request is made.
- R10: `done` is 1 for exactly one cycle, the cycle after the index-2 request is accepted, and no request follows it.
- R11: A `rsp_valid` strobe while no response is awaited (for example during the wake-up period) has no effect on the wake-up length or on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply is at operating level |
| ramp_cycles | input | RAMP_W | Supply ramp time in clock cycles |
| ocr_window | input | 32 | Operating voltage window used as the index-1 argument |
| bus_clk_en | output | 1 | Bus clock enable |
| cmd_ones | output | 1 | Sequencer drives the command line high |
| req_valid | output | 1 | Command request to the engine |
| req_index | output | 6 | Command index (1 or 2) |
| req_arg | output | 32 | Command argument |
| req_ready | input | 1 | Engine accepts the request |
| rsp_valid | input | 1 | Response strobe from the engine |
| rsp_busy | input | 1 | Busy flag of the response (1 = not ready) |
| done | output | 1 | One-cycle pulse when identification has been issued |
| timeout | output | 1 | Sticky flag: busy after the last allowed attempt |

## Verification
The bench aims at the wake-up length in each of its three regimes. A second instance with a low clock count shows the 74-cycle floor, so a design that loads the wrong limit or counts one cycle off gives a wrong run of ones. The retry path is pushed to its boundary: a ready answer on the last allowed attempt must still reach the identification command, and a busy answer on that same attempt must raise `timeout`. An off-by-one attempt counter fails one of these two cases. Stray response strobes during the wake-up period, random engine latencies and random ramp values check that the gap length, argument stability and the single-cycle `done` do not depend on handshake timing.

// File: rtl/cardbus_pwrup_pkg.sv
package cardbus_pwrup_pkg;

    localparam int READY_CYCLES = 64;
    localparam int SYNC_MARGIN  = 10;
    localparam int WAKE_FLOOR   = READY_CYCLES + SYNC_MARGIN;

    localparam logic [5:0] IDX_OP_COND = 6'd1;
    localparam logic [5:0] IDX_ALL_ID  = 6'd2;

    typedef enum logic [2:0] {
        WAIT_POWER,
        INIT_ONES,
        SEND_CMD1,
        WAIT_RESP,
        GAP,
        SEND_CMD2,
        DONE,
        ERROR
    } seq_state_t;

endpackage

// File: rtl/pwrup_wake_len.sv
module pwrup_wake_len
    import cardbus_pwrup_pkg::*;
#(
    parameter int W         = 16,
    parameter int MS_CYCLES = 50000,
    parameter int RAMP_W    = 16
) (
    input  logic [RAMP_W-1:0] ramp,
    output logic [W-1:0]      len
);
    localparam logic [W-1:0] MS_LIM    = W'(MS_CYCLES);
    localparam logic [W-1:0] FLOOR_LIM = W'(WAKE_FLOOR);

    logic [W-1:0] fixed_lim;
    logic [W-1:0] ramp_lim;

    always_comb begin
        fixed_lim = (MS_LIM > FLOOR_LIM) ? MS_LIM : FLOOR_LIM;
        ramp_lim  = W'(ramp);
        len       = (ramp_lim > fixed_lim) ? ramp_lim : fixed_lim;
    end
endmodule

// File: rtl/pwrup_down_timer.sv
module pwrup_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/pwrup_try_ctr.sv
module pwrup_try_ctr #(
    parameter int MAX_TRIES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [TW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clr) begin
            tries_q <= '0;
        end else if (inc && (tries_q != TW'(MAX_TRIES))) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign at_limit = (tries_q == TW'(MAX_TRIES));
endmodule

// File: rtl/cardbus_pwrup_seq.sv
module cardbus_pwrup_seq
    import cardbus_pwrup_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int RAMP_W    = 16,
    parameter int NCC       = 8,
    parameter int MAX_TRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic [RAMP_W-1:0] ramp_cycles,
    input  logic [31:0]       ocr_window,
    output logic              bus_clk_en,
    output logic              cmd_ones,
    output logic              req_valid,
    output logic [5:0]        req_index,
    output logic [31:0]       req_arg,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_busy,
    output logic              done,
    output logic              timeout
);
    localparam int MS_W  = $clog2(CLK_KHZ + 1);
    localparam int GAP_W = $clog2(NCC + 1);
    localparam int W_A   = (RAMP_W > MS_W) ? RAMP_W : MS_W;
    localparam int W_B   = (W_A > GAP_W) ? W_A : GAP_W;
    localparam int CNT_W = (W_B > 7) ? W_B : 7;

    seq_state_t state_q, state_d;
    logic       next_id_q, next_id_d;
    logic       done_seen_q;

    logic [CNT_W-1:0] wake_len;
    logic [CNT_W-1:0] t_val;
    logic             t_load;
    logic             t_last;
    logic             try_clr;
    logic             try_inc;
    logic             try_limit;

    pwrup_wake_len #(
        .W        (CNT_W),
        .MS_CYCLES(CLK_KHZ),
        .RAMP_W   (RAMP_W)
    ) u_len (
        .ramp(ramp_cycles),
        .len (wake_len)
    );

    pwrup_down_timer #(
        .W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .last    (t_last)
    );

    pwrup_try_ctr #(
        .MAX_TRIES(MAX_TRIES)
    ) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (try_clr),
        .inc     (try_inc),
        .at_limit(try_limit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= WAIT_POWER;
            next_id_q   <= 1'b0;
            done_seen_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            next_id_q   <= next_id_d;
            done_seen_q <= (state_q == DONE);
        end
    end

    // Next state and sub-block control
    always_comb begin
        state_d   = state_q;
        next_id_d = next_id_q;
        t_load    = 1'b0;
        t_val     = wake_len;
        try_clr   = 1'b0;
        try_inc   = 1'b0;
        unique case (state_q)
            WAIT_POWER: begin
                if (pwr_ok) begin
                    t_load  = 1'b1;
                    state_d = INIT_ONES;
                end
            end
            INIT_ONES: begin
                if (t_last) begin
                    try_clr   = 1'b1;
                    next_id_d = 1'b0;
                    state_d   = SEND_CMD1;
                end
            end
            SEND_CMD1: begin
                if (req_ready) begin
                    try_inc = 1'b1;
                    state_d = WAIT_RESP;
                end
            end
            WAIT_RESP: begin
                if (rsp_valid) begin
                    if (!rsp_busy) begin
                        next_id_d = 1'b1;
                        t_load    = 1'b1;
                        t_val     = CNT_W'(NCC);
                        state_d   = GAP;
                    end else if (try_limit) begin
                        state_d = ERROR;
                    end else begin
                        next_id_d = 1'b0;
                        t_load    = 1'b1;
                        t_val     = CNT_W'(NCC);
                        state_d   = GAP;
                    end
                end
            end
            GAP: begin
                if (t_last) begin
                    state_d = next_id_q ? SEND_CMD2 : SEND_CMD1;
                end
            end
            SEND_CMD2: begin
                if (req_ready) begin
                    state_d = DONE;
                end
            end
            DONE:  state_d = DONE;
            ERROR: state_d = ERROR;
            default: state_d = WAIT_POWER;
        endcase
    end

    // Outputs
    always_comb begin
        bus_clk_en = (state_q != WAIT_POWER);
        cmd_ones   = (state_q == INIT_ONES) || (state_q == GAP);
        req_valid  = 1'b0;
        req_index  = 6'd0;
        req_arg    = 32'd0;
        unique case (state_q)
            SEND_CMD1: begin
                req_valid = 1'b1;
                req_index = IDX_OP_COND;
                req_arg   = ocr_window;
            end
            SEND_CMD2: begin
                req_valid = 1'b1;
                req_index = IDX_ALL_ID;
            end
            default: ;
        endcase
        done    = (state_q == DONE) && !done_seen_q;
        timeout = (state_q == ERROR);
    end

    initial begin
        if (NCC < 1)       $error("NCC must be at least 1");
        if (MAX_TRIES < 1) $error("MAX_TRIES must be at least 1");
    end
endmodule

// File: rtl/cardbus_pwrup_seq_chk.sv
module cardbus_pwrup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ocr_window,
    input logic        bus_clk_en,
    input logic        cmd_ones,
    input logic        req_valid,
    input logic [5:0]  req_index,
    input logic [31:0] req_arg,
    input logic        req_ready,
    input logic        done,
    input logic        timeout
);
    a_r1_quiet_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clk_en |-> (!req_valid && !cmd_ones && !done && !timeout));

    a_r2_clock_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_en |=> bus_clk_en);

    a_r2_ones_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk_en) |-> cmd_ones);

    a_r4_cmd1_argument: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_index == 6'd1) |-> (req_arg == ocr_window));

    a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

    a_r5_request_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    a_r7_legal_index: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_index == 6'd1 || (req_index == 6'd2 && req_arg == 32'd0)));

    a_r8_line_owner: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ones |-> !req_valid);

    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    a_r9_silent_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!req_valid && !done));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !req_valid));
endmodule

bind cardbus_pwrup_seq cardbus_pwrup_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ocr_window(ocr_window),
    .bus_clk_en(bus_clk_en),
    .cmd_ones  (cmd_ones),
    .req_valid (req_valid),
    .req_index (req_index),
    .req_arg   (req_arg),
    .req_ready (req_ready),
    .done      (done),
    .timeout   (timeout)
);

// File: tb/cardbus_pwrup_seq_test.sv
module cardbus_pwrup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ        = 100;
    localparam int KHZ_LO     = 20;
    localparam int NCC_T      = 8;
    localparam int TRIES      = 4;
    localparam int RW         = 16;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic [RW-1:0] ramp_cycles = '0;
    logic [31:0]   ocr = '0;
    logic          req_ready = 1'b0;
    logic          rsp_valid = 1'b0;
    logic          rsp_busy = 1'b0;

    logic          bus_clk_en, cmd_ones, req_valid, done, timeout;
    logic [5:0]    req_index;
    logic [31:0]   req_arg;

    logic          lo_clk_en, lo_ones, lo_valid, lo_done, lo_timeout;
    logic [5:0]    lo_index;
    logic [31:0]   lo_arg;

    cardbus_pwrup_seq #(.CLK_KHZ(KHZ), .RAMP_W(RW), .NCC(NCC_T), .MAX_TRIES(TRIES)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ramp_cycles(ramp_cycles),
        .ocr_window(ocr), .bus_clk_en(bus_clk_en), .cmd_ones(cmd_ones),
        .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_busy(rsp_busy),
        .done(done), .timeout(timeout)
    );

    cardbus_pwrup_seq #(.CLK_KHZ(KHZ_LO), .RAMP_W(RW), .NCC(NCC_T), .MAX_TRIES(TRIES)) uut_lo (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ramp_cycles(ramp_cycles),
        .ocr_window(ocr), .bus_clk_en(lo_clk_en), .cmd_ones(lo_ones),
        .req_valid(lo_valid), .req_index(lo_index), .req_arg(lo_arg),
        .req_ready(1'b1), .rsp_valid(1'b0), .rsp_busy(1'b0),
        .done(lo_done), .timeout(lo_timeout)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int lo_count = 0;

    always @(negedge clk) begin
        if (!rst_n) lo_count <= 0;
        else if (lo_ones) lo_count <= lo_count + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wake_expect(input int khz, input int ramp);
        int m = khz;
        if (74 > m) m = 74;
        if (ramp > m) m = ramp;
        return m;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_ok = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_busy = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic hold_and_accept(input logic [5:0] idx, input logic [31:0] arg);
        int d = $urandom_range(0, 3);
        for (int i = 0; i < d; i++) begin
            step();
            chk(req_valid && req_index == idx && req_arg == arg, "R5 request held", req_index, idx);
        end
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
        chk(!req_valid, "R5 request dropped after accept", req_valid, 0);
    endtask

    task automatic scenario(input int ramp, input int nbusy, input bit inject, input bit check_lo);
        int ones;
        int gap;
        int exp_len;
        bit busy;
        bit seen;
        ramp_cycles = RW'(ramp);
        ocr = $urandom;
        do_reset();
        repeat (4) step();
        chk(!bus_clk_en && !cmd_ones && !req_valid && !done && !timeout, "R1 quiet before power",
            {bus_clk_en, cmd_ones, req_valid, done, timeout}, 0);
        pwr_ok = 1'b1;
        step();
        chk(bus_clk_en, "R2 clock enabled", bus_clk_en, 1);
        ones = 0;
        while (cmd_ones && ones < 100000) begin
            ones++;
            rsp_valid = inject && (ones == 5);
            step();
        end
        rsp_valid = 1'b0;
        exp_len = wake_expect(KHZ, ramp);
        if (inject) chk(ones == exp_len, "R11 stray response ignored (wake length)", ones, exp_len);
        else        chk(ones == exp_len, "R2 wake length", ones, exp_len);
        if (check_lo) chk(lo_count == wake_expect(KHZ_LO, ramp), "R3 floor of 74", lo_count, wake_expect(KHZ_LO, ramp));
        chk(req_valid && req_index == 6'd1 && req_arg == ocr, "R4 first request is index 1", req_index, 1);
        for (int a = 1; a <= TRIES; a++) begin
            hold_and_accept(6'd1, ocr);
            repeat ($urandom_range(0, 4)) step();
            busy = (a <= nbusy);
            rsp_valid = 1'b1;
            rsp_busy  = busy;
            step();
            rsp_valid = 1'b0;
            rsp_busy  = 1'b0;
            if (busy && a == TRIES) begin
                chk(timeout, "R9 timeout raised", timeout, 1);
                seen = 1'b0;
                repeat (20) begin
                    step();
                    if (req_valid || !timeout || done) seen = 1'b1;
                end
                chk(!seen, "R9 silent and sticky after timeout", seen, 0);
                return;
            end
            gap = 0;
            while (cmd_ones && gap < 1000) begin
                gap++;
                step();
            end
            chk(gap == NCC_T, "R8 gap length", gap, NCC_T);
            if (busy) begin
                chk(req_valid && req_index == 6'd1 && req_arg == ocr, "R6 retry index 1 after busy", req_index, 1);
            end else begin
                chk(req_valid && req_index == 6'd2 && req_arg == 32'd0, "R7 index 2 after ready", req_index, 2);
                hold_and_accept(6'd2, 32'd0);
                chk(done, "R10 done after accept", done, 1);
                step();
                chk(!done, "R10 done lasts one cycle", done, 0);
                seen = 1'b0;
                repeat (10) begin
                    step();
                    if (req_valid || done) seen = 1'b1;
                end
                chk(!seen, "R10 no request after done", seen, 0);
                return;
            end
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        step();
        scenario(10, 0, 1'b0, 1'b1);
        scenario(250, 2, 1'b0, 1'b0);
        scenario(0, TRIES - 1, 1'b0, 1'b0);
        scenario(40, TRIES, 1'b0, 1'b0);
        scenario(120, 1, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            scenario($urandom_range(0, 300), $urandom_range(0, TRIES), 1'b0, 1'b0);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule